// File: doc/BRIEF.md
# Sigma-Delta Overload Window Detector

This block is the protection side of an isolated measurement channel. It takes the same one-bit modulator stream that feeds the main filter and runs it through a coarse sinc filter with a short decimation ratio. The filter is third or fourth order. Each settled output is scaled to a 16-bit unsigned word and compared against a programmable low/high window. A zero input, which is a 50% ones density, lands at mid-scale.

A sample outside the window sets a sticky overload flag and drives an interrupt request. The first such sample since the flag was last clear also produces a single-cycle trip pulse. That pulse is meant for a fast PWM shutdown path. Software clears the flag by pulsing a write-one-to-clear input. One instance serves one modulator channel, and a system with four channels places four instances.

Top module: `sdo_limit_detect`

## Requirements
- R1: While and just after synchronous reset, `ovl_flag`, `trip`, `irq` and `samp_valid` are all low.
- R2: With `en` high, a bit is accepted only in cycles where `mod_valid` is high, and `mod_bit` is ignored otherwise. Exactly one `samp_valid` pulse follows each 2^`dec_sel` accepted bits, one cycle after the last of them, and no two pulses are adjacent. `dec_sel` is legal from 1 to `MAX_DLOG`; 0 is treated as 1 and larger values as `MAX_DLOG`.
- R3: For a bit pattern that repeats every D = 2^k accepted bits and holds p ones per period, every output from the (order+1)-th onward equals min(p·2^(16−k), 0xFFFF). So a 50% density reads 0x8000.
- R4: `order_sel` = 0 selects a third-order filter and 1 selects a fourth-order filter. After `en` rises, the first 3 or 4 outputs respectively are never compared against the window.
- R5: A compared output violates the window when it is strictly below `lim_lo` or strictly above `lim_hi`. A value equal to either limit is inside. Limits of 0x0000 and 0xFFFF never trip.
- R6: `ovl_flag` rises in the cycle after a violating output and stays high until `ovl_clr` is sampled high. If a violation and a clear arrive in the same cycle, the flag stays set.
- R7: `trip` is a one-cycle pulse in the cycle after a violating output, issued only if `ovl_flag` was low in the cycle of that output.
- R8: `irq` is high exactly when `ovl_flag` is high.
- R9: Lowering `en` restarts the decimation phase, the filter state and the settling count, so the first output after re-enable comes after exactly D accepted bits. `ovl_flag` keeps its value while `en` is low, and no trip occurs in a cycle that follows a disabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Channel enable; low clears the filter path |
| mod_valid | input | 1 | Modulator sample strobe |
| mod_bit | input | 1 | Modulator data bit |
| dec_sel | input | KW (3) | log2 of the decimation ratio |
| order_sel | input | 1 | 0 = third order, 1 = fourth order |
| lim_lo | input | OUT_W (16) | Lower window limit, unsigned |
| lim_hi | input | OUT_W (16) | Upper window limit, unsigned |
| ovl_clr | input | 1 | Write-one-to-clear pulse for the flag |
| samp_data | output | OUT_W (16) | Scaled filter output |
| samp_valid | output | 1 | One-cycle strobe for `samp_data` |
| ovl_flag | output | 1 | Sticky overload flag |
| trip | output | 1 | One-cycle shutdown pulse |
| irq | output | 1 | Interrupt request, level |

## Verification
The filter is driven with periodic patterns of every ones-count p from 0 to D, for each decimation ratio and both orders. The zero and full-density ends separate saturation from ordinary scaling, and the middle values expose any error in gain or shift. The sample strobe has gaps, and the data pin carries inverted bits while the strobe is low, so any sample taken outside a strobe changes the result. Window limits placed exactly on, one above and one below the expected value isolate the strict comparison. Patterns whose early partial outputs fall below the low limit show whether the settling guard works. Cases that stop halfway through a decimation period, followed by a fresh start, show whether disabling really clears the phase.

// File: rtl/sdo_pkg.sv
// Shared constants for the sigma-delta overload detector.
// Assumes the filter order is either ORDER_MIN or ORDER_MAX.
package sdo_pkg;
    localparam int ORDER_MIN = 3;
    localparam int ORDER_MAX = 4;

    // Accumulator width that holds D^ORDER_MAX without loss for D = 2^max_dlog.
    function automatic int acc_width(input int max_dlog);
        return ORDER_MAX * max_dlog + 1;
    endfunction
endpackage

// File: rtl/sdo_integ.sv
// Integrator cascade of the coarse sinc filter. Every stage adds the freshly
// updated value of the stage before it, so there is no pipeline delay in the
// sample domain. Wrap-around arithmetic is intended: the comb section undoes it.
// Assumes ACC_W is wide enough for the largest D^order.
module sdo_integ #(
    parameter int ACC_W  = 21,
    parameter int STAGES = sdo_pkg::ORDER_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             din,
    input  logic             ord4,
    output logic [ACC_W-1:0] x_out
);
    for (genvar j = 0; j < STAGES; j++) begin : g_st
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] nv;
        if (j == 0) begin : g_first
            assign nv = acc + ACC_W'(din);
        end else begin : g_next
            assign nv = acc + g_st[j-1].nv;
        end
        // Accumulate one accepted bit; cleared on reset or disable.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) acc <= '0;
            else if (step)       acc <= nv;
        end
    end

    // Tap the last stage that the selected order uses.
    assign x_out = ord4 ? g_st[STAGES-1].nv : g_st[STAGES-2].nv;
endmodule

// File: rtl/sdo_comb.sv
// Comb (differentiator) cascade run at the decimated rate, then scaling to an
// OUT_W-bit unsigned word with saturation at full density. Full scale D^order
// maps to 2^OUT_W, which is clipped to all ones.
// Assumes tick is never high in two adjacent cycles.
module sdo_comb #(
    parameter int ACC_W    = 21,
    parameter int STAGES   = sdo_pkg::ORDER_MAX,
    parameter int OUT_W    = 16,
    parameter int KW       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [ACC_W-1:0] x_in,
    input  logic             ord4,
    input  logic [KW-1:0]    klog,
    output logic [OUT_W-1:0] data,
    output logic             valid
);
    localparam int SW = ACC_W + OUT_W;

    for (genvar j = 0; j < STAGES; j++) begin : g_st
        logic [ACC_W-1:0] dly;
        logic [ACC_W-1:0] cv;
        logic [ACC_W-1:0] src;
        if (j == 0) begin : g_first
            assign src = x_in;
        end else begin : g_next
            assign src = g_st[j-1].cv;
        end
        assign cv = src - dly;
        // Hold the previous decimated input of this stage.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) dly <= '0;
            else if (tick)       dly <= src;
        end
    end

    logic [ACC_W-1:0] raw;
    logic [7:0]       tot;
    logic [SW-1:0]    wide;
    logic [OUT_W-1:0] scaled;

    assign raw = ord4 ? g_st[STAGES-1].cv : g_st[STAGES-2].cv;
    assign tot = (ord4 ? 8'(sdo_pkg::ORDER_MAX) : 8'(sdo_pkg::ORDER_MIN)) * 8'(klog);

    // Align the gain D^order onto 2^OUT_W and saturate the top code.
    always_comb begin
        if (tot <= 8'(OUT_W)) wide = SW'(raw) << (8'(OUT_W) - tot);
        else                  wide = SW'(raw) >> (tot - 8'(OUT_W));
        scaled = (|wide[SW-1:OUT_W]) ? '1 : wide[OUT_W-1:0];
    end

    // Register the decimated output and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= tick && !clear;
            if (tick) data <= scaled;
        end
    end
endmodule

// File: rtl/sdo_window.sv
// Window comparator with settling guard, sticky flag and trip pulse.
// The first ORDER outputs after enable are ignored. A violation outranks a
// clear in the same cycle. Assumes valid is a one-cycle strobe.
module sdo_window #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ord4,
    input  logic             valid,
    input  logic [OUT_W-1:0] data,
    input  logic [OUT_W-1:0] lim_lo,
    input  logic [OUT_W-1:0] lim_hi,
    input  logic             clr,
    output logic             flag,
    output logic             trip
);
    logic [2:0] settle;
    logic [2:0] target;
    logic       armed;
    logic       viol;

    assign target = ord4 ? 3'(sdo_pkg::ORDER_MAX) : 3'(sdo_pkg::ORDER_MIN);
    assign armed  = (settle == target);
    assign viol   = en && valid && armed && ((data < lim_lo) || (data > lim_hi));

    // Count outputs since enable until the filter has settled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)        settle <= '0;
        else if (valid && !armed) settle <= settle + 3'd1;
    end

    // Sticky flag with set priority; trip only on the first violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            trip <= 1'b0;
        end else begin
            trip <= viol && !flag;
            flag <= (flag && !clr) || viol;
        end
    end
endmodule

// File: rtl/sdo_limit_detect.sv
// Top of the overload detector: decimation counter, integrators, combs and
// window logic for one modulator channel. Configuration inputs are expected to
// change only while en is low.
module sdo_limit_detect #(
    parameter int OUT_W    = 16,
    parameter int MAX_DLOG = 5,
    parameter int KW       = $clog2(MAX_DLOG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mod_valid,
    input  logic             mod_bit,
    input  logic [KW-1:0]    dec_sel,
    input  logic             order_sel,
    input  logic [OUT_W-1:0] lim_lo,
    input  logic [OUT_W-1:0] lim_hi,
    input  logic             ovl_clr,
    output logic [OUT_W-1:0] samp_data,
    output logic             samp_valid,
    output logic             ovl_flag,
    output logic             trip,
    output logic             irq
);
    localparam int ACC_W = sdo_pkg::acc_width(MAX_DLOG);

    logic [KW-1:0]       klog;
    logic [MAX_DLOG-1:0] dmask;
    logic [MAX_DLOG-1:0] phase;
    logic                step;
    logic                tick;
    logic [ACC_W-1:0]    integ_x;

    // Clamp the ratio selector into the supported range.
    always_comb begin
        if (dec_sel == '0)                 klog = KW'(1);
        else if (dec_sel > KW'(MAX_DLOG))  klog = KW'(MAX_DLOG);
        else                               klog = dec_sel;
    end

    assign dmask = (MAX_DLOG'(1) << klog) - MAX_DLOG'(1);
    assign step  = en && mod_valid;
    assign tick  = step && (phase == dmask);

    // Position within the current decimation period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) phase <= '0;
        else if (step)     phase <= tick ? '0 : phase + MAX_DLOG'(1);
    end

    sdo_integ #(.ACC_W(ACC_W), .STAGES(sdo_pkg::ORDER_MAX)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!en),
        .step  (step),
        .din   (mod_bit),
        .ord4  (order_sel),
        .x_out (integ_x)
    );

    sdo_comb #(.ACC_W(ACC_W), .STAGES(sdo_pkg::ORDER_MAX), .OUT_W(OUT_W), .KW(KW)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!en),
        .tick  (tick),
        .x_in  (integ_x),
        .ord4  (order_sel),
        .klog  (klog),
        .data  (samp_data),
        .valid (samp_valid)
    );

    sdo_window #(.OUT_W(OUT_W)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .ord4   (order_sel),
        .valid  (samp_valid),
        .data   (samp_data),
        .lim_lo (lim_lo),
        .lim_hi (lim_hi),
        .clr    (ovl_clr),
        .flag   (ovl_flag),
        .trip   (trip)
    );

    assign irq = ovl_flag;
endmodule

// File: rtl/sdo_limit_detect_chk.sv
// Temporal checks on the detector's ports, attached by bind.
module sdo_limit_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic samp_valid,
    input logic ovl_flag,
    input logic ovl_clr,
    input logic trip
);
    a_r2_valid_gap: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |=> !samp_valid);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_flag && !ovl_clr) |=> ovl_flag);

    a_r6_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovl_flag) |-> ($past(samp_valid) && $past(en)));

    a_r7_trip_single: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> !trip);

    a_r7_trip_first: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> (ovl_flag && !$past(ovl_flag)));

    a_r9_no_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !trip);
endmodule

bind sdo_limit_detect sdo_limit_detect_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .samp_valid (samp_valid),
    .ovl_flag   (ovl_flag),
    .ovl_clr    (ovl_clr),
    .trip       (trip)
);

// File: tb/sdo_limit_detect_test.sv
`timescale 1ns/1ps
module sdo_limit_detect_test;
    localparam int OUT_W    = 16;
    localparam int MAX_DLOG = 5;
    localparam int KW       = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en;
    logic             mod_valid;
    logic             mod_bit;
    logic [KW-1:0]    dec_sel;
    logic             order_sel;
    logic [OUT_W-1:0] lim_lo;
    logic [OUT_W-1:0] lim_hi;
    logic             ovl_clr;
    logic [OUT_W-1:0] samp_data;
    logic             samp_valid;
    logic             ovl_flag;
    logic             trip;
    logic             irq;

    always #4 clk = ~clk;

    sdo_limit_detect #(.OUT_W(OUT_W), .MAX_DLOG(MAX_DLOG), .KW(KW)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .mod_valid(mod_valid), .mod_bit(mod_bit),
        .dec_sel(dec_sel), .order_sel(order_sel), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .ovl_clr(ovl_clr), .samp_data(samp_data), .samp_valid(samp_valid),
        .ovl_flag(ovl_flag), .trip(trip), .irq(irq)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  exp_flag = 1'b0;
    bit  exp_trip = 1'b0;
    bit  en_now = 1'b0;
    bit  clr_mode = 1'b0;
    int  m_cnt, g_nsamp, cur_D, cur_N, cur_e;
    int  cur_lo, cur_hi;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // One clock: observe outputs, advance the model, drive the next inputs.
    task automatic do_cycle(input bit en_v, input bit mv, input bit b, input bit clr_force);
        bit viol;
        bit clr_v;
        @(negedge clk);
        check(ovl_flag == exp_flag, "R6 flag", int'(ovl_flag), int'(exp_flag));
        check(trip == exp_trip, "R7 trip", int'(trip), int'(exp_trip));
        check(irq == exp_flag, "R8 irq", int'(irq), int'(exp_flag));
        viol = 1'b0;
        if (samp_valid && en_now) begin
            m_cnt++;
            check(g_nsamp == m_cnt * cur_D, "R2 output spacing (R9 phase)", g_nsamp, m_cnt * cur_D);
            if (m_cnt > cur_N) begin
                check(int'(samp_data) == cur_e, "R3 settled value", int'(samp_data), cur_e);
                viol = (cur_e < cur_lo) || (cur_e > cur_hi); // R5 strict window, R4 guard
            end
        end
        clr_v    = clr_force || (clr_mode && samp_valid && en_now);
        exp_trip = viol && !exp_flag;
        exp_flag = (exp_flag && !clr_v) || viol;
        en        = en_v;
        mod_valid = mv;
        mod_bit   = b;
        ovl_clr   = clr_v;
        en_now    = en_v;
    endtask

    task automatic run_case(input int k, input bit o4, input int p, input int lo, input int hi,
                            input bit cm, input bit partial);
        int target;
        int cyc;
        int nout;
        bit mv;
        bit b;
        clr_mode = 1'b0;
        do_cycle(1'b0, 1'b0, 1'b0, 1'b0); // R9: flag held while disabled
        do_cycle(1'b0, 1'b0, 1'b0, 1'b1);
        cur_D   = 1 << k;
        cur_N   = o4 ? 4 : 3;
        cur_e   = p << (16 - k);
        if (cur_e > 65535) cur_e = 65535;
        cur_lo  = lo;
        cur_hi  = hi;
        dec_sel   = KW'(k);
        order_sel = o4;
        lim_lo    = OUT_W'(lo);
        lim_hi    = OUT_W'(hi);
        do_cycle(1'b0, 1'b0, 1'b0, 1'b0);
        m_cnt    = 0;
        g_nsamp  = 0;
        clr_mode = cm;
        nout     = cur_N + 3;
        target   = nout * cur_D + (partial ? cur_D / 2 : 0);
        cyc      = 0;
        while (g_nsamp < target) begin
            mv = (cyc % 3) != 0;
            b  = (g_nsamp % cur_D) < p;
            if (!mv) b = ~b; // R2: junk on idle cycles
            do_cycle(1'b1, mv, b, 1'b0);
            if (mv) g_nsamp++;
            cyc++;
        end
        repeat (4) do_cycle(1'b1, 1'b0, 1'b0, 1'b0);
        check(m_cnt == nout, "R2 output count", m_cnt, nout);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; mod_valid = 1'b0; mod_bit = 1'b0;
        dec_sel = KW'(3); order_sel = 1'b0; lim_lo = '0; lim_hi = '1; ovl_clr = 1'b0;
        repeat (3) @(negedge clk);
        check(!ovl_flag && !trip && !irq && !samp_valid, "R1 reset state",
              int'({ovl_flag, trip, irq, samp_valid}), 0);
        rst_n = 1'b1;
        // Sweep of every density, ratio and order; odd p leaves a half period (R9).
        for (int o = 0; o < 2; o++)
            for (int k = 1; k <= MAX_DLOG; k++)
                for (int p = 0; p <= (1 << k); p++)
                    run_case(k, o[0], p, 'h2000, 'hE000, 1'b0, p[0]);
        // R5 boundaries around 0x6000 (k=3, p=3).
        run_case(3, 1'b0, 3, 'h6000, 'h6000, 1'b0, 1'b0);
        run_case(3, 1'b0, 3, 'h6001, 'hFFFF, 1'b0, 1'b0);
        run_case(3, 1'b1, 3, 'h0000, 'h5FFF, 1'b0, 1'b0);
        run_case(2, 1'b1, 4, 'h0000, 'hFFFF, 1'b0, 1'b0);
        // R4: mid-scale with low limit above partial outputs must not trip.
        run_case(4, 1'b1, 8, 'h7000, 'h9000, 1'b0, 1'b0);
        // R6: clear coincides with each violation; flag stays, single trip (R7).
        run_case(2, 1'b1, 0, 'h1000, 'hFFFF, 1'b1, 1'b0);
        run_case(1, 1'b0, 2, 'h0000, 'hC000, 1'b1, 1'b0);
        run_case(3, 1'b0, 4, 'h0000, 'hFFFF, 1'b0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule